// File: doc/BRIEF.md
# Memory Device Boundary Scan Test Port

This block is the serial test port of a memory device. A sixteen-state controller is clocked by `tck` and steered by `tms`, and an optional asynchronous `trst_n` can force it into its reset state. The controller moves serial data from `tdi` to `tdo` through one of two paths. The first is a 3-bit instruction register. The second is a data register picked by the active instruction: a 1-bit bypass stage, a 32-bit identification word, or a 69-bit boundary register. The boundary register loads the sampled pad ring from the parallel input `ring_in`.

The instruction set does not follow the general standard at the boundary register. Three opcodes capture the ring and put the boundary register on the serial path. None of the three ever preloads a value. Two of them also raise `hiz_force`, which tells the memory's output drivers to go high impedance. Unused opcodes act as bypass so that the chain stays continuous. The identification word, the register widths and the reset opcode are parameters. A parameter chooses whether the asynchronous reset pin is used.

Top module: `mem_scan_port`

## Requirements
- R1: Five successive `tck` rising edges with `tms` high put the controller into its reset state from any state. The state transitions follow the standard sixteen-state graph.
- R2: A low level on `trst_n` forces the reset state at once, without waiting for a clock edge.
- R3: While the controller is in its reset state, the instruction register is loaded with IDCODE (001) and `hiz_force` is low.
- R4: In the instruction capture state, the instruction shift stage loads 001. This appears on `tdo` as a 1 followed by two 0s.
- R5: A new instruction takes effect only when leaving the instruction update state. Shifting instruction bits leaves `hiz_force` unchanged.
- R6: IDCODE (001) loads the identification word on data capture. The word is revision in bits 31:29 (default 001), device code in bits 28:12 (default 01011001000100110), vendor code in bits 11:1 (default 00000110100) and 1 in bit 0.
- R7: BYPASS (111) places a single stage on the path. That stage captures 0, so data leaves one clock late.
- R8: The opcodes 011, 101 and 110 act exactly as BYPASS.
- R9: SAMPLE/PRELOAD (100) captures `ring_in` into the boundary register and shifts it out least significant bit first. It keeps `hiz_force` low.
- R10: EXTEST (000) captures and shifts the ring in the same way as R9 and drives `hiz_force` high.
- R11: SAMPLE Z (010) captures and shifts the ring in the same way as R9 and drives `hiz_force` high.
- R12: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only in the two shift states. Every register shifts toward bit 0, and `tdi` enters at the top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low (used when USE_TRST=1) |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| ring_in | input | BSR_W | Sampled pad ring values for boundary capture |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| hiz_force | output | 1 | Forces the memory output drivers to high impedance |

## Verification
The bench builds the block with its default parameters: the asynchronous reset pin enabled, a 69-bit boundary register and the default identification fields. This lets it read the full identification word and shift the whole boundary register out in one pass. With the reset pin present, the bench can compare the pin reset against the five-clock `tms` reset. Because a non-zero ring pattern spans all 69 bits, a wrong shift direction or an off-by-one tap on the boundary register shows up at the top bits.

// File: rtl/mem_scan_pkg.sv
`timescale 1ns/1ps
package mem_scan_pkg;

   typedef enum logic [3:0] {
      ST_RESET   = 4'd0,
      ST_IDLE    = 4'd1,
      ST_SEL_DR  = 4'd2,
      ST_CAP_DR  = 4'd3,
      ST_SH_DR   = 4'd4,
      ST_EX1_DR  = 4'd5,
      ST_PAU_DR  = 4'd6,
      ST_EX2_DR  = 4'd7,
      ST_UPD_DR  = 4'd8,
      ST_SEL_IR  = 4'd9,
      ST_CAP_IR  = 4'd10,
      ST_SH_IR   = 4'd11,
      ST_EX1_IR  = 4'd12,
      ST_PAU_IR  = 4'd13,
      ST_EX2_IR  = 4'd14,
      ST_UPD_IR  = 4'd15
   } tap_state_e;

   typedef enum logic [1:0] {
      PATH_BYP = 2'd0,
      PATH_ID  = 2'd1,
      PATH_BSR = 2'd2
   } dr_path_e;

   localparam int unsigned OPC_W = 3;

   localparam logic [OPC_W-1:0] OPC_EXT   = 3'b000;
   localparam logic [OPC_W-1:0] OPC_IDC   = 3'b001;
   localparam logic [OPC_W-1:0] OPC_SMPZ  = 3'b010;
   localparam logic [OPC_W-1:0] OPC_SMPL  = 3'b100;
   localparam logic [OPC_W-1:0] OPC_BYP   = 3'b111;

   function automatic dr_path_e opc_path(input logic [OPC_W-1:0] opc);
      case (opc)
         OPC_EXT, OPC_SMPZ, OPC_SMPL: opc_path = PATH_BSR;
         OPC_IDC:                     opc_path = PATH_ID;
         default:                     opc_path = PATH_BYP;
      endcase
   endfunction

   function automatic logic opc_hiz(input logic [OPC_W-1:0] opc);
      opc_hiz = (opc == OPC_EXT) || (opc == OPC_SMPZ);
   endfunction

endpackage

// File: rtl/mem_scan_fsm.sv
`timescale 1ns/1ps
module mem_scan_fsm
   import mem_scan_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      case (state)
         ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         default:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= ST_RESET;
      else        state <= nxt;
   end

endmodule

// File: rtl/mem_scan_ir.sv
`timescale 1ns/1ps
module mem_scan_ir #(
   parameter int unsigned        IR_W     = 3,
   parameter logic [IR_W-1:0]    RST_CODE = '0,
   parameter logic [IR_W-1:0]    CAP_PAT  = '0
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tdi,
   input  logic            in_reset,
   input  logic            cap,
   input  logic            shift,
   input  logic            upd,
   output logic [IR_W-1:0] active,
   output logic            sh_lsb
);

   logic [IR_W-1:0] sh_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)     sh_q <= CAP_PAT;
      else if (cap)   sh_q <= CAP_PAT;
      else if (shift) sh_q <= {tdi, sh_q[IR_W-1:1]};
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)        active <= RST_CODE;
      else if (in_reset) active <= RST_CODE;
      else if (upd)      active <= sh_q;
   end

   assign sh_lsb = sh_q[0];

endmodule

// File: rtl/mem_scan_dr.sv
`timescale 1ns/1ps
module mem_scan_dr
   import mem_scan_pkg::*;
#(
   parameter int unsigned       ID_W   = 32,
   parameter int unsigned       BSR_W  = 69,
   parameter logic [ID_W-1:0]   ID_VAL = '0
) (
   input  logic             tck,
   input  logic             rst_n,
   input  logic             tdi,
   input  dr_path_e         path,
   input  logic             cap,
   input  logic             shift,
   input  logic [BSR_W-1:0] ring,
   output logic             dr_lsb
);

   logic             byp_q;
   logic [ID_W-1:0]  id_q;
   logic [BSR_W-1:0] bsr_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= 1'b0;
         id_q  <= ID_VAL;
         bsr_q <= '0;
      end else begin
         case (path)
            PATH_ID: begin
               if (cap)        id_q <= ID_VAL;
               else if (shift) id_q <= {tdi, id_q[ID_W-1:1]};
            end
            PATH_BSR: begin
               if (cap)        bsr_q <= ring;
               else if (shift) bsr_q <= {tdi, bsr_q[BSR_W-1:1]};
            end
            default: begin
               if (cap)        byp_q <= 1'b0;
               else if (shift) byp_q <= tdi;
            end
         endcase
      end
   end

   always_comb begin
      case (path)
         PATH_ID:  dr_lsb = id_q[0];
         PATH_BSR: dr_lsb = bsr_q[0];
         default:  dr_lsb = byp_q;
      endcase
   end

endmodule

// File: rtl/mem_scan_port.sv
`timescale 1ns/1ps
module mem_scan_port
   import mem_scan_pkg::*;
#(
   parameter int unsigned   IR_W     = 3,
   parameter int unsigned   ID_W     = 32,
   parameter int unsigned   BSR_W    = 69,
   parameter bit            USE_TRST = 1'b1,
   parameter logic [2:0]    ID_REV   = 3'b001,
   parameter logic [16:0]   ID_DEV   = 17'b01011001000100110,
   parameter logic [10:0]   ID_VEND  = 11'b00000110100
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   input  logic [BSR_W-1:0] ring_in,
   output logic             tdo,
   output logic             tdo_en,
   output logic             hiz_force
);

   localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_DEV, ID_VEND, 1'b1};
   localparam logic [IR_W-1:0] IR_CAP  = {{(IR_W-1){1'b0}}, 1'b1};

   if (IR_W != OPC_W) begin : g_bad_ir
      $error("instruction width must equal the opcode width");
   end
   if (ID_W != 32) begin : g_bad_id
      $error("identification word must be 32 bits");
   end
   if (BSR_W < 2) begin : g_bad_bsr
      $error("boundary register needs at least two stages");
   end

   logic rst_n;
   if (USE_TRST) begin : g_trst
      assign rst_n = trst_n;
   end else begin : g_no_trst
      assign rst_n = 1'b1;
   end

   tap_state_e      st;
   logic [IR_W-1:0] ir_q;
   logic            ir_lsb;
   logic            dr_lsb;
   dr_path_e        path;

   mem_scan_fsm u_fsm (
      .tck   (tck),
      .rst_n (rst_n),
      .tms   (tms),
      .state (st)
   );

   mem_scan_ir #(
      .IR_W     (IR_W),
      .RST_CODE (OPC_IDC),
      .CAP_PAT  (IR_CAP)
   ) u_ir (
      .tck      (tck),
      .rst_n    (rst_n),
      .tdi      (tdi),
      .in_reset (st == ST_RESET),
      .cap      (st == ST_CAP_IR),
      .shift    (st == ST_SH_IR),
      .upd      (st == ST_UPD_IR),
      .active   (ir_q),
      .sh_lsb   (ir_lsb)
   );

   assign path      = opc_path(ir_q);
   assign hiz_force = opc_hiz(ir_q);

   mem_scan_dr #(
      .ID_W   (ID_W),
      .BSR_W  (BSR_W),
      .ID_VAL (ID_WORD)
   ) u_dr (
      .tck    (tck),
      .rst_n  (rst_n),
      .tdi    (tdi),
      .path   (path),
      .cap    (st == ST_CAP_DR),
      .shift  (st == ST_SH_DR),
      .ring   (ring_in),
      .dr_lsb (dr_lsb)
   );

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo    <= (st == ST_SH_IR) ? ir_lsb : dr_lsb;
         tdo_en <= (st == ST_SH_IR) || (st == ST_SH_DR);
      end
   end

endmodule

// File: rtl/mem_scan_port_chk.sv
`timescale 1ns/1ps
module mem_scan_port_chk
   import mem_scan_pkg::*;
(
   input logic       tck,
   input logic       trst_n,
   input logic       tms,
   input logic       tdo_en,
   input logic       hiz,
   input tap_state_e state,
   input logic [2:0] ir
);

   logic [2:0] hi_cnt;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)        hi_cnt <= '0;
      else if (!tms)      hi_cnt <= '0;
      else if (hi_cnt < 5) hi_cnt <= hi_cnt + 3'd1;
   end

   // R1
   five_high_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_cnt == 3'd5) |-> (state == ST_RESET));

   // R3
   reset_loads_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RESET) |=> (ir == OPC_IDC && !hiz));

   // R5
   ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir));

   // R5
   hiz_rise_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(hiz) |-> ($past(state) == ST_UPD_IR));

   // R12
   tdo_en_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en == (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind mem_scan_port mem_scan_port_chk u_chk (
   .tck    (tck),
   .trst_n (trst_n),
   .tms    (tms),
   .tdo_en (tdo_en),
   .hiz    (hiz_force),
   .state  (st),
   .ir     (ir_q)
);

// File: tb/mem_scan_port_bench.sv
`timescale 1ns/1ps
module mem_scan_port_bench;

   localparam int BSR_W = 69;

   logic             tck = 1'b0;
   logic             trst_n = 1'b0;
   logic             tms = 1'b1;
   logic             tdi = 1'b0;
   logic [BSR_W-1:0] ring_in = '0;
   logic             tdo, tdo_en, hiz_force;

   int errors = 0;
   int checks = 0;
   logic en_bad;
   logic hiz_moved;

   always #5 tck = ~tck;

   mem_scan_port u_mem_scan_port (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .ring_in(ring_in), .tdo(tdo), .tdo_en(tdo_en), .hiz_force(hiz_force)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clk_bit(input logic m, input logic d, output logic q);
      tms = m; tdi = d;
      @(negedge tck); #2 q = tdo;
      @(posedge tck); #1;
   endtask

   task automatic shift_path(input int n, input logic [127:0] din, output logic [127:0] dout);
      logic q;
      logic h0;
      dout = '0;
      h0 = hiz_force;
      for (int i = 0; i < n; i++) begin
         clk_bit(i == n - 1, din[i], q);
         dout[i] = q;
         if (tdo_en !== 1'b1) en_bad = 1'b1;
         if (hiz_force !== h0) hiz_moved = 1'b1;
      end
   endtask

   task automatic scan_ir(input logic [2:0] code, output logic [2:0] got);
      logic q;
      logic [127:0] o;
      clk_bit(1, 0, q); clk_bit(1, 0, q); clk_bit(0, 0, q); clk_bit(0, 0, q);
      shift_path(3, {125'd0, code}, o);
      got = o[2:0];
      clk_bit(1, 0, q); clk_bit(0, 0, q);
   endtask

   task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
      logic q;
      clk_bit(1, 0, q); clk_bit(0, 0, q); clk_bit(0, 0, q);
      shift_path(n, din, dout);
      clk_bit(1, 0, q); clk_bit(0, 0, q);
   endtask

   function automatic logic [31:0] id_word();
      return {3'b001, 17'b01011001000100110, 11'b00000110100, 1'b1};
   endfunction

   task automatic t_reset_state();
      logic [127:0] o;
      logic q;
      chk("R2 tdo_en in reset", {127'd0, tdo_en}, 128'd0);
      chk("R3 hiz after reset", {127'd0, hiz_force}, 128'd0);
      clk_bit(0, 0, q);
      chk("R12 tdo_en idle", {127'd0, tdo_en}, 128'd0);
      en_bad = 1'b0;
      scan_dr(32, '0, o);
      chk("R6 idcode word", o, {96'd0, id_word()});
      chk("R12 tdo_en during shift", {127'd0, en_bad}, 128'd0);
   endtask

   task automatic t_ir_capture();
      logic [2:0] got;
      scan_ir(3'b001, got);
      chk("R4 capture pattern", {125'd0, got}, 128'd1);
   endtask

   task automatic t_bypass(input logic [2:0] code, input string req);
      logic [2:0] got;
      logic [127:0] o;
      scan_ir(code, got);
      scan_dr(8, 128'hA5, o);
      chk(req, o, {120'd0, 8'h4A});
      chk(req, {127'd0, hiz_force}, 128'd0);
   endtask

   task automatic t_ring(input logic [2:0] code, input logic exp_hiz, input string req);
      logic [2:0] got;
      logic [127:0] o;
      logic [BSR_W-1:0] pat;
      pat = {5'b10110, 32'hDEADBEEF, 32'h01234567} ^ {BSR_W{code[0]}};
      ring_in = pat;
      scan_ir(code, got);
      chk(req, {127'd0, hiz_force}, {127'd0, exp_hiz});
      scan_dr(BSR_W, '0, o);
      chk(req, o, {59'd0, pat});
   endtask

   task automatic t_update_only();
      logic [2:0] got;
      scan_ir(3'b000, got);
      hiz_moved = 1'b0;
      scan_ir(3'b111, got);
      chk("R5 hiz stable while shifting", {127'd0, hiz_moved}, 128'd0);
      chk("R5 new opcode applied at update", {127'd0, hiz_force}, 128'd0);
   endtask

   task automatic t_tms_reset();
      logic [2:0] got;
      logic [127:0] o;
      logic q;
      scan_ir(3'b010, got);
      chk("R11 precondition hiz", {127'd0, hiz_force}, 128'd1);
      for (int i = 0; i < 5; i++) clk_bit(1, 0, q);
      chk("R1 five tms high releases hiz", {127'd0, hiz_force}, 128'd0);
      clk_bit(0, 0, q);
      scan_dr(32, '0, o);
      chk("R3 idcode after tms reset", o, {96'd0, id_word()});
   endtask

   task automatic t_trst();
      logic [2:0] got;
      logic [127:0] o;
      logic q;
      scan_ir(3'b000, got);
      tms = 1'b0;
      @(negedge tck); #1 trst_n = 1'b0;
      #1 chk("R2 async reset releases hiz", {127'd0, hiz_force}, 128'd0);
      @(posedge tck); #1 trst_n = 1'b1;
      clk_bit(0, 0, q);
      scan_dr(32, '0, o);
      chk("R3 idcode after pin reset", o, {96'd0, id_word()});
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      trst_n = 1'b0;
      repeat (3) @(posedge tck);
      #1 trst_n = 1'b1;
      t_reset_state();
      t_ir_capture();
      t_bypass(3'b111, "R7 bypass");
      t_bypass(3'b011, "R8 reserved 011");
      t_bypass(3'b101, "R8 reserved 101");
      t_bypass(3'b110, "R8 reserved 110");
      t_ring(3'b100, 1'b0, "R9 sample preload");
      t_ring(3'b000, 1'b1, "R10 extest");
      t_ring(3'b010, 1'b1, "R11 sample z");
      t_update_only();
      t_tms_reset();
      t_trst();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule